// File: doc/BRIEF.md
# Dual-Port RAM with Same-Location Busy Arbitration

This block is a word-addressed memory reached through two independent ports, called left and right. Each port has its own address, write data, read data, chip enable, write enable and output enable. Either port can read or write any location at any time. When both enabled ports point at the same location, the block chooses one of them to keep access and marks the other as busy. The busy port sees an active-low flag, and any write it attempts is dropped.

The winner is the port whose chip enable and address were already in place when the other port arrived. If the addresses already matched when the enables came in, the earlier enable decides. If both ports were already enabled, the address that stopped moving first decides. A tie within one clock goes to the left port. A mode input turns the two busy pins into inputs. This lets several copies be stacked side by side to build a wider word, with one copy arbitrating for all of them. All behaviour is modelled as logic sampled on one clock. Reads are registered, and the read data register of a busy port holds its value while that port's controls stay still.

Top module: `dpbusy_ram`

## Requirements
- R1: A port stores its write data at its address at a clock edge only when its chip enable and its write enable are both low (and it is not busy). With either one high, memory is unchanged. Read data comes from a register loaded at the clock edge, so a value written at edge k can be read back after edge k+1.
- R2: In master mode (slaveMode = 0), a busy output is low only while both chip enables are low and the two addresses are equal. At most one port is busy at a time.
- R3: If the addresses already match and one port's chip enable goes low while the other's is already low, the port that was enabled first keeps access. The newly enabled port receives busy.
- R4: If both ports are enabled and their addresses come to match, the port whose address did not change in that cycle keeps access. The port that moved receives busy.
- R5: If both ports start a same-address access in the same clock cycle, with no earlier ordering, the left port keeps access and the right port receives busy.
- R6: Busy is released in the same cycle that the addresses differ or either chip enable goes high. While contention continues, the same port stays busy.
- R7: In master mode, a write attempted by the busy port leaves memory unchanged.
- R8: In slave mode (slaveMode = 1), both busy outputs stay high and no arbitration takes place. A port whose busy input is low has its writes suppressed. A port whose busy input is high writes normally.
- R9: The read data of a busy port holds its value, even while the winning port writes that location. It holds until busy is released or the busy port changes its address, chip enable or write enable.
- R10: A port's data-drive output is high only when its chip enable is low, its output enable is low and its write enable is high. While data-drive is low, its read data output is 0.
- R11: While reset is low, both busy outputs are high. After reset, both read data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| slaveMode | input | 1 | 1: busy pins act as inputs, no arbitration |
| leftCeN | input | 1 | Left chip enable, active low |
| leftWeN | input | 1 | Left write enable, active low |
| leftOeN | input | 1 | Left output enable, active low |
| leftAddr | input | 11 | Left address |
| leftDataIn | input | 8 | Left write data |
| leftDataOut | output | 8 | Left read data, 0 when not driven |
| leftDataDrive | output | 1 | Left read data is being driven |
| leftBusyInN | input | 1 | Left busy from the arbitrating copy (slave mode) |
| leftBusyOutN | output | 1 | Left busy flag, active low (master mode) |
| rightCeN | input | 1 | Right chip enable, active low |
| rightWeN | input | 1 | Right write enable, active low |
| rightOeN | input | 1 | Right output enable, active low |
| rightAddr | input | 11 | Right address |
| rightDataIn | input | 8 | Right write data |
| rightDataOut | output | 8 | Right read data, 0 when not driven |
| rightDataDrive | output | 1 | Right read data is being driven |
| rightBusyInN | input | 1 | Right busy from the arbitrating copy (slave mode) |
| rightBusyOutN | output | 1 | Right busy flag, active low (master mode) |

## Verification
The assertions check on every cycle the properties that hold without history:
- busy appears only when both ports are enabled on one address;
- the two ports are never busy together;
- busy is released as soon as the match ends;
- a losing port stays busy while contention lasts;
- slave mode keeps the flags quiet;
- no write strobe fires without its enables, or on both ports at one address in master mode.

Which port wins under enable ordering, address ordering and ties, that a blocked write really leaves memory intact, and that a loser's read data freezes and later updates can only be shown by the bench scenarios, which read memory back through the ports.

// File: rtl/dpbusy_pkg.sv
package dpbusy_pkg;

  // Which port currently holds a contended location
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrLeft;
    logic wrRight;
    logic rdLeft;
    logic rdRight;
  } strobes_t;

endpackage

// File: rtl/dpbusy_port_track.sv
// Remembers one port's last sampled controls to tell whether it has settled or moved.
module dpbusy_port_track #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  output logic              settled,
  output logic              changed
);

  logic              prevAct;
  logic              prevWeN;
  logic [ADDR_W-1:0] prevAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevAct  <= 1'b0;
      prevWeN  <= 1'b1;
      prevAddr <= '0;
    end else begin
      prevAct  <= !ceN;
      prevWeN  <= weN;
      prevAddr <= addr;
    end
  end

  // Enabled last cycle on the same address and still enabled now
  assign settled = prevAct && !ceN && (prevAddr == addr);
  assign changed = (prevAct != !ceN) || (prevAddr != addr) || (prevWeN != weN);

endmodule

// File: rtl/dpbusy_ctrl.sv
module dpbusy_ctrl
  import dpbusy_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slaveMode,
  input  logic              leftCeN,
  input  logic              leftWeN,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              leftBusyInN,
  input  logic              rightCeN,
  input  logic              rightWeN,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              rightBusyInN,
  output strobes_t          strobes,
  output logic              leftBusyOutN,
  output logic              rightBusyOutN
);

  logic   leftSettled, leftChanged, rightSettled, rightChanged;
  logic   contend;
  logic   leftLoses, rightLoses;
  logic   leftBlocked, rightBlocked;
  owner_e ownerReg, freshWinner, curWinner;

  dpbusy_port_track #(.ADDR_W(ADDR_W)) u_trackLeft (
    .clk(clk), .rstN(rstN), .ceN(leftCeN), .weN(leftWeN), .addr(leftAddr),
    .settled(leftSettled), .changed(leftChanged)
  );

  dpbusy_port_track #(.ADDR_W(ADDR_W)) u_trackRight (
    .clk(clk), .rstN(rstN), .ceN(rightCeN), .weN(rightWeN), .addr(rightAddr),
    .settled(rightSettled), .changed(rightChanged)
  );

  assign contend = !slaveMode && !leftCeN && !rightCeN && (leftAddr == rightAddr);

  // The side already in place wins; a tie goes left
  always_comb begin
    if (rightSettled && !leftSettled) freshWinner = OWN_RIGHT;
    else                              freshWinner = OWN_LEFT;
  end

  assign curWinner = (ownerReg != OWN_NONE) ? ownerReg : freshWinner;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        ownerReg <= OWN_NONE;
    else if (contend) ownerReg <= curWinner;
    else              ownerReg <= OWN_NONE;
  end

  assign leftLoses  = rstN && contend && (curWinner == OWN_RIGHT);
  assign rightLoses = rstN && contend && (curWinner == OWN_LEFT);

  assign leftBusyOutN  = !leftLoses;
  assign rightBusyOutN = !rightLoses;

  assign leftBlocked  = slaveMode ? !leftBusyInN  : leftLoses;
  assign rightBlocked = slaveMode ? !rightBusyInN : rightLoses;

  always_comb begin
    strobes.wrLeft  = !leftCeN  && !leftWeN  && !leftBlocked;
    strobes.wrRight = !rightCeN && !rightWeN && !rightBlocked;
    // A blocked port keeps its read register until its own controls move
    strobes.rdLeft  = !leftBlocked  || leftChanged;
    strobes.rdRight = !rightBlocked || rightChanged;
  end

  AST_BUSY_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (!leftBusyOutN || !rightBusyOutN) |-> (!leftCeN && !rightCeN && leftAddr == rightAddr)); // R2

  AST_SINGLE_LOSER: assert property (@(posedge clk) disable iff (!rstN)
    !(!leftBusyOutN && !rightBusyOutN)); // R2

  AST_RELEASE_ON_END: assert property (@(posedge clk) disable iff (!rstN)
    (leftCeN || rightCeN || leftAddr != rightAddr) |-> (leftBusyOutN && rightBusyOutN)); // R6

  AST_LOSER_KEPT_RIGHT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!rightBusyOutN) && !slaveMode && !leftCeN && !rightCeN && leftAddr == rightAddr)
      |-> !rightBusyOutN); // R6

  AST_LOSER_KEPT_LEFT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!leftBusyOutN) && !slaveMode && !leftCeN && !rightCeN && leftAddr == rightAddr)
      |-> !leftBusyOutN); // R6

  AST_SLAVE_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    slaveMode |-> (leftBusyOutN && rightBusyOutN)); // R8

endmodule

// File: rtl/dpbusy_dpath.sv
module dpbusy_dpath
  import dpbusy_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slaveMode,
  input  strobes_t          strobes,
  input  logic              leftCeN,
  input  logic              leftWeN,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic [DATA_W-1:0] leftDataIn,
  input  logic              rightCeN,
  input  logic              rightWeN,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic [DATA_W-1:0] rightDataIn,
  output logic [DATA_W-1:0] leftRdq,
  output logic [DATA_W-1:0] rightRdq
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] memArr [DEPTH];

  // Left is written last so it wins a same-address collision (slave misuse only)
  always_ff @(posedge clk) begin
    if (strobes.wrRight) memArr[rightAddr] <= rightDataIn;
    if (strobes.wrLeft)  memArr[leftAddr]  <= leftDataIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      leftRdq  <= '0;
      rightRdq <= '0;
    end else begin
      if (strobes.rdLeft)  leftRdq  <= memArr[leftAddr];
      if (strobes.rdRight) rightRdq <= memArr[rightAddr];
    end
  end

  AST_WRITE_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrLeft |-> (!leftCeN && !leftWeN)) and
    (strobes.wrRight |-> (!rightCeN && !rightWeN))); // R1

  AST_NO_DOUBLE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !(!slaveMode && strobes.wrLeft && strobes.wrRight && leftAddr == rightAddr)); // R7

endmodule

// File: rtl/dpbusy_ram.sv
module dpbusy_ram
  import dpbusy_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slaveMode,
  input  logic              leftCeN,
  input  logic              leftWeN,
  input  logic              leftOeN,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic [DATA_W-1:0] leftDataIn,
  output logic [DATA_W-1:0] leftDataOut,
  output logic              leftDataDrive,
  input  logic              leftBusyInN,
  output logic              leftBusyOutN,
  input  logic              rightCeN,
  input  logic              rightWeN,
  input  logic              rightOeN,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic [DATA_W-1:0] rightDataIn,
  output logic [DATA_W-1:0] rightDataOut,
  output logic              rightDataDrive,
  input  logic              rightBusyInN,
  output logic              rightBusyOutN
);

  strobes_t          strobes;
  logic [DATA_W-1:0] leftRdq, rightRdq;

  dpbusy_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .slaveMode(slaveMode),
    .leftCeN(leftCeN), .leftWeN(leftWeN), .leftAddr(leftAddr), .leftBusyInN(leftBusyInN),
    .rightCeN(rightCeN), .rightWeN(rightWeN), .rightAddr(rightAddr), .rightBusyInN(rightBusyInN),
    .strobes(strobes), .leftBusyOutN(leftBusyOutN), .rightBusyOutN(rightBusyOutN)
  );

  dpbusy_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .slaveMode(slaveMode), .strobes(strobes),
    .leftCeN(leftCeN), .leftWeN(leftWeN), .leftAddr(leftAddr), .leftDataIn(leftDataIn),
    .rightCeN(rightCeN), .rightWeN(rightWeN), .rightAddr(rightAddr), .rightDataIn(rightDataIn),
    .leftRdq(leftRdq), .rightRdq(rightRdq)
  );

  // Output stage: a disabled or writing port presents zeros
  assign leftDataDrive  = !leftCeN  && !leftOeN  && leftWeN;
  assign rightDataDrive = !rightCeN && !rightOeN && rightWeN;
  assign leftDataOut    = leftDataDrive  ? leftRdq  : '0;
  assign rightDataOut   = rightDataDrive ? rightRdq : '0;

  AST_DRIVE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    ((leftDataOut != '0) |-> leftDataDrive) and ((rightDataOut != '0) |-> rightDataDrive)); // R10

endmodule

// File: tb/dpbusy_ram_tb.sv
module dpbusy_ram_tb;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, slave;
  logic        lCe, lWe, lOe, lBi, rCe, rWe, rOe, rBi;
  logic [10:0] lA, rA;
  logic [7:0]  lD, rD;
  logic [7:0]  lQ, rQ;
  logic        lDrv, rDrv, lBo, rBo;
  int          nChecks = 0;
  int          nFails  = 0;
  bit          done    = 1'b0;

  dpbusy_ram u_dut (
    .clk(clk), .rstN(rstN), .slaveMode(slave),
    .leftCeN(lCe), .leftWeN(lWe), .leftOeN(lOe), .leftAddr(lA), .leftDataIn(lD),
    .leftDataOut(lQ), .leftDataDrive(lDrv), .leftBusyInN(lBi), .leftBusyOutN(lBo),
    .rightCeN(rCe), .rightWeN(rWe), .rightOeN(rOe), .rightAddr(rA), .rightDataIn(rD),
    .rightDataOut(rQ), .rightDataDrive(rDrv), .rightBusyInN(rBi), .rightBusyOutN(rBo)
  );

  // One row: left ce, left addr, right ce, right addr, expected left/right busy
  typedef struct packed {
    logic        lce;
    logic [10:0] la;
    logic        rce;
    logic [10:0] ra;
    logic        lbz;
    logic        rbz;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 11'd5, 1'b1, 11'd0, 1'b1, 1'b1},
    '{1'b0, 11'd5, 1'b0, 11'd5, 1'b1, 1'b0},  // R3 left enabled first
    '{1'b0, 11'd5, 1'b0, 11'd5, 1'b1, 1'b0},  // R6 kept
    '{1'b0, 11'd5, 1'b0, 11'd6, 1'b1, 1'b1},  // R6 mismatch
    '{1'b0, 11'd5, 1'b0, 11'd5, 1'b1, 1'b0},  // R4 right moved
    '{1'b1, 11'd5, 1'b0, 11'd5, 1'b1, 1'b1},  // R6 winner ce high
    '{1'b0, 11'd5, 1'b0, 11'd5, 1'b0, 1'b1},  // R3 right enabled first
    '{1'b1, 11'd0, 1'b1, 11'd0, 1'b1, 1'b1},
    '{1'b0, 11'd9, 1'b0, 11'd9, 1'b1, 1'b0},  // R5 tie
    '{1'b1, 11'd0, 1'b1, 11'd0, 1'b1, 1'b1},
    '{1'b0, 11'd3, 1'b0, 11'd4, 1'b1, 1'b1},
    '{1'b0, 11'd4, 1'b0, 11'd4, 1'b0, 1'b1},  // R4 left moved
    '{1'b1, 11'd0, 1'b1, 11'd0, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    lCe = 1; lWe = 1; lOe = 0; lA = '0; lD = '0;
    rCe = 1; rWe = 1; rOe = 0; rA = '0; rD = '0;
    lBi = 1; rBi = 1;
  endtask

  task automatic leftWrite(input logic [10:0] a, input logic [7:0] d);
    lCe = 0; lWe = 0; lA = a; lD = d;
    cyc();
    lCe = 1; lWe = 1;
    cyc();
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    slave = 0; rstN = 0; idle();
    // During reset both ports contend on address 0
    lCe = 0; rCe = 0;
    repeat (3) cyc();
    #1;
    chk("R11 busy in reset", {14'd0, lBo, rBo}, 16'h0003);
    rstN = 1;
    idle();
    cyc(); #1;
    chk("R11 left data", {8'd0, lQ}, 16'h0000);
    chk("R11 right data", {8'd0, rQ}, 16'h0000);

    // Busy table walk (R2 R3 R4 R5 R6)
    for (int i = 0; i < NVEC; i++) begin
      lCe = VECS[i].lce; lA = VECS[i].la;
      rCe = VECS[i].rce; rA = VECS[i].ra;
      #1;
      chk($sformatf("R2/R3/R4/R5/R6 row %0d", i), {14'd0, lBo, rBo},
          {14'd0, VECS[i].lbz, VECS[i].rbz});
      cyc();
    end
    idle();
    cyc();

    // R1: write then read through the other port
    leftWrite(11'd10, 8'hA5);
    rCe = 0; rA = 11'd10;
    cyc(); #1;
    chk("R1 readback", {8'd0, rQ}, 16'h00A5);
    // Write enable low with chip enable high must not store
    rCe = 1;
    lCe = 1; lWe = 0; lA = 11'd10; lD = 8'h11;
    cyc();
    lWe = 1; rCe = 0;
    cyc(); #1;
    chk("R1 no write without ce", {8'd0, rQ}, 16'h00A5);
    idle(); cyc();

    // R7: busy left write suppressed
    leftWrite(11'd20, 8'h3C);
    rCe = 0; rA = 11'd20;
    cyc();
    lCe = 0; lWe = 0; lA = 11'd20; lD = 8'hFF;
    #1;
    chk("R7 left busy", {14'd0, lBo, rBo}, 16'h0001);
    cyc();
    lCe = 1; lWe = 1;
    cyc(); #1;
    chk("R7 memory intact", {8'd0, rQ}, 16'h003C);
    idle(); cyc();

    // R9: loser read data freezes while winner writes
    leftWrite(11'd30, 8'h55);
    lCe = 0; lA = 11'd30;
    cyc();
    rCe = 0; rA = 11'd30;
    cyc(); #1;
    chk("R9 right busy", {15'd0, rBo}, 16'h0000);
    chk("R9 first read", {8'd0, rQ}, 16'h0055);
    lWe = 0; lD = 8'h77;
    cyc(); #1;
    chk("R9 held after write", {8'd0, rQ}, 16'h0055);
    lWe = 1;
    cyc(); #1;
    chk("R9 still held", {8'd0, rQ}, 16'h0055);
    lCe = 1;
    cyc(); #1;
    chk("R9 updated after release", {8'd0, rQ}, 16'h0077);
    idle(); cyc();

    // R10: drive qualification
    lCe = 0; lOe = 0; lWe = 1; #1;
    chk("R10 drive on", {15'd0, lDrv}, 16'h0001);
    lOe = 1; #1;
    chk("R10 oe high", {8'd0, lDrv, lQ[6:0]}, 16'h0000);
    lOe = 0; lWe = 0; #1;
    chk("R10 writing", {15'd0, lDrv}, 16'h0000);
    lWe = 1; lCe = 1; #1;
    chk("R10 ce high", {15'd0, lDrv}, 16'h0000);
    idle(); cyc();

    // R8: slave mode
    leftWrite(11'd41, 8'h12);
    slave = 1;
    lCe = 0; rCe = 0; lA = 11'd40; rA = 11'd40; #1;
    chk("R8 no busy out", {14'd0, lBo, rBo}, 16'h0003);
    cyc();
    rBi = 0; rWe = 0; rA = 11'd41; rD = 8'h99;
    lBi = 1; lWe = 0; lA = 11'd42; lD = 8'h66;
    cyc();
    idle();
    rCe = 0; rA = 11'd41;
    cyc(); #1;
    chk("R8 blocked write", {8'd0, rQ}, 16'h0012);
    rA = 11'd42;
    cyc(); #1;
    chk("R8 free write", {8'd0, rQ}, 16'h0066);

    done = 1'b1;
    finishRun();
  end

endmodule